// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the sample-rate enable for a UART receiver and transmitter that oversample each bit sixteen times. It divides the peripheral clock by a divisor of the form `1 + F/4`, where `F` is an unsigned field written into a divider register. The integer part of that divisor sets the spacing between ticks. The two fractional bits feed a small accumulator that adds one extra clock to some periods, so the average spacing is exact in quarter-clock steps. The output is a one-cycle enable that the frame engine uses to advance its bit-timing state.

Software computes `F` from the peripheral clock and the target rate. The rate on the line is `4·fclk / (16·(4 + F))`. `F = 0` gives the fastest rate, `fclk/16`. The widest field gives periods of more than 8192 clocks, so the slowest rate of `fclk/(16·8192)` can be reached. Each register write restarts the timing from a known phase.

Top module: `fracbaud_gen`

## Requirements
- R1: After reset the divider field is 0, and `tick` is high on every clock cycle.
- R2: On a write, `F` is taken from `cfg_wdata[20:6]`, where bit 6 carries a weight of one quarter clock. Bits 5:0 and bits 31:21 have no effect on the timing of `tick`.
- R3: Number the clock cycles after the edge that samples a write, starting from 1. The n-th tick after the write is high in cycle `floor((n-1)·(4+F)/4) + floor((4+F)/4)`, and in no other cycle up to the next write.
- R4: A write that arrives partway through a period discards both the count in progress and the fractional accumulator. Tick timing then restarts exactly as R3 gives for the new `F`.
- R5: When the integer period `floor((4+F)/4)` is greater than 1, `tick` is never high for two consecutive cycles.
- R6: With `F = 0`, `tick` stays high on every cycle.
- R7: When `F` is a multiple of 4, every interval between ticks is `1 + F/4` cycles. For any other `F`, each interval is either the integer period or one cycle longer.
- R8: The largest field values are supported without overflow. `F = 32764` gives a period of 8192 cycles, and `F = 32767` gives an average period of 8192.75 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Divider register write strobe |
| cfg_wdata | input | 32 | Divider register write data; the field is in bits 20:6 |
| tick | output | 1 | One-cycle oversampling enable |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a period while the accumulator holds a nonzero phase. Both the partial count and the fractional remainder must then be discarded.

The stimulus gets there in two steps:
- It first runs a field with a nonzero fractional part long enough for the accumulator to wrap at least once.
- It then ends that window on a cycle that is not a multiple of the period and writes a new field at once.

The scoreboard expects the new tick positions measured from the second write only. Any timing left over from the earlier field shows up as an early or a missing tick.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  localparam int unsigned FRAC_BITS = 2;

  // Integer part of the tick period in clocks: floor((4+F)/4) = 1 + F>>2
  function automatic int unsigned whole_period(input int unsigned f);
    return 1 + (f >> FRAC_BITS);
  endfunction

  // Quarter-clock remainder added through the accumulator
  function automatic int unsigned quarter_part(input int unsigned f);
    return f & ((1 << FRAC_BITS) - 1);
  endfunction

endpackage

// File: rtl/fbd_cfg.sv
module fbd_cfg #(
  parameter int REG_W     = 32,
  parameter int FIELD_LSB = 6,
  parameter int FIELD_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  output logic [FIELD_W-1:0] wfield,
  output logic [FIELD_W-1:0] field_q
);

  assign wfield = wdata[FIELD_LSB +: FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  field_q <= '0;
    else if (we) field_q <= wfield;
  end

endmodule

// File: rtl/fbd_phase.sv
module fbd_phase #(
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] acc_q,
  output logic              carry
);

  logic [FRAC_W:0] sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear)   acc_q <= '0;
    else if (advance) acc_q <= sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/fbd_count.sv
module fbd_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (expire) cnt_q <= reload_val;
    else             cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen #(
  parameter int REG_W     = 32,
  parameter int FIELD_LSB = 6,
  parameter int FIELD_W   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             tick
);
  import fbd_pkg::*;

  localparam int FRAC_W = FRAC_BITS;
  localparam int CNT_W  = FIELD_W - FRAC_W + 1;

  logic [FIELD_W-1:0] wfield, field_q;
  logic [FRAC_W-1:0]  acc_q, frac_cur;
  logic               carry, period_end, acc_advance;
  logic [CNT_W-1:0]   ip_cur, ip_new, load_val, reload_val, cnt_q;

  fbd_cfg #(.REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .wfield(wfield), .field_q(field_q)
  );

  assign ip_cur     = CNT_W'(whole_period(int'(field_q)));
  assign ip_new     = CNT_W'(whole_period(int'(wfield)));
  assign frac_cur   = FRAC_W'(quarter_part(int'(field_q)));
  assign load_val   = ip_new - 1'b1;
  assign reload_val = ip_cur + CNT_W'(carry) - 1'b1;

  assign acc_advance = period_end & ~cfg_we;

  fbd_phase #(.FRAC_W(FRAC_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(cfg_we), .advance(acc_advance),
    .frac(frac_cur), .acc_q(acc_q), .carry(carry)
  );

  fbd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .load_val(load_val),
    .reload_val(reload_val), .cnt_q(cnt_q), .expire(period_end)
  );

  assign tick = period_end;

endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
  parameter int CNT_W  = 14,
  parameter int FRAC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             tick,
  input logic             carry,
  input logic [FRAC_W-1:0] acc_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ip_cur
);

  // R4: a write empties the fractional accumulator
  a_r4_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (acc_q == '0));

  // R4: a write restarts the count at one full integer period
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt_q == ip_cur - 1'b1));

  // R7: the count never exceeds the integer period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ip_cur);

  // R3: a carry stretches the next period by one clock
  a_r3_carry_len: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && carry && !cfg_we) |=> (cnt_q == ip_cur));

  // R5: the pulse lasts one cycle when the period is longer than one
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_we && ip_cur > 1) |=> !tick);

  // R3: between ticks the count steps down by one
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

bind fracbaud_gen fbd_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tick(tick), .carry(carry),
  .acc_q(acc_q), .cnt_q(cnt_q), .ip_cur(ip_cur)
);

// File: tb/fracbaud_gen_tb.sv
module fracbaud_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tick;

  int     n_cmp = 0;
  int     n_bad = 0;
  longint exp_q[$];
  longint idx = 0;
  longint win_len = 0;
  bit     active = 1'b0;
  bit     done = 1'b0;
  string  cur_tag = "R3";

  fracbaud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: a write edge starts cycle numbering at 1
  always @(posedge clk) begin
    if (rst_n && cfg_we) begin
      idx    = 0;
      active = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (active) begin
      idx++;
      if (idx <= win_len && tick) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: tick in cycle %0d, expected none", cur_tag, idx);
        end else begin
          longint e;
          e = exp_q.pop_front();
          if (e != idx) begin
            n_bad++;
            $display("FAIL %s: tick in cycle %0d, expected cycle %0d", cur_tag, idx, e);
          end
        end
      end
    end
  end

  // Driver: write F (with junk in ignored bits), predict ticks for len cycles
  task automatic run_case(input int f, input logic [5:0] lo, input logic [10:0] hi,
                          input longint len, input string tag);
    longint per4;
    longint t;
    per4 = 4 + f;
    exp_q.delete();
    for (longint n = 1; ; n++) begin
      t = ((n - 1) * per4) / 4 + per4 / 4;
      if (t > len) break;
      exp_q.push_back(t);
    end
    cur_tag = tag;
    win_len = len;
    @(posedge clk); #1;
    cfg_wdata = {hi, f[14:0], lo};
    cfg_we    = 1'b1;
    @(posedge clk); #1;
    cfg_we    = 1'b0;
    repeat (len) @(negedge clk);
    #1;
    active = 1'b0;
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d ticks missing, next expected cycle %0d, expected 0 missing",
               tag, exp_q.size(), exp_q[0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset value F=0 means a tick on every cycle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_cmp++;
      if (tick !== 1'b1) begin
        n_bad++;
        $display("FAIL R1: tick=%b after reset, expected 1", tick);
      end
    end
    run_case(0,     6'h00, 11'h000, 12,    "R6");
    run_case(5,     6'h3F, 11'h7FF, 40,    "R2");
    run_case(5,     6'h00, 11'h000, 40,    "R3");
    run_case(6,     6'h15, 11'h000, 40,    "R3");
    run_case(7,     6'h00, 11'h2AA, 50,    "R5");
    run_case(8,     6'h00, 11'h000, 40,    "R7");
    run_case(13,    6'h00, 11'h000, 23,    "R3");
    run_case(2,     6'h00, 11'h000, 20,    "R4");
    run_case(1,     6'h00, 11'h000, 17,    "R4");
    run_case(3,     6'h2A, 11'h000, 10,    "R6");
    run_case(32764, 6'h00, 11'h000, 17000, "R8");
    run_case(32767, 6'h00, 11'h000, 25000, "R8");
    done = 1'b1;
  end

  initial begin
    int c;
    c = 0;
    while (!done && c < WATCHDOG) begin
      @(posedge clk);
      c++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run not finished after %0d cycles, expected completion", c);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule